// File: doc/BRIEF.md
# Heater Relay Time-Proportioning PWM

This block turns a heater power request into a slow on/off pattern for a solid-state relay that switches an oven heater. A period lasts 1500 ticks of an external 1 ms strobe, which gives one duty step per millisecond across a 1.5 s window. That window is slow enough for a zero-cross relay to follow.

The profile sequencer selects one of three heater modes. In off mode the heater is held dark. Full mode keeps the relay energised for ramps. In regulated mode, used while holding a temperature, the on-time is proportional to the gap between setpoint and measured temperature, so the heater backs off as the oven approaches its target. The gate output is active high and drives a low-side transistor that feeds the relay input. An abort input overrides every mode. The regulated on-time is sampled only at period boundaries, so a period in progress is never cut short or stretched by a new measurement.

Top module: `ssr_pwm_drv`

## Requirements
- R1: During and right after synchronous reset the gate is low, the latched on-time is zero and the tick counter is at zero. The gate stays low even when regulated mode is requested straight out of reset.
- R2: The tick counter advances by one only on cycles where `tick_i` is high. It wraps from 1499 to 0. Without ticks the counter and the gate do not change.
- R3: The mode encoding is 2'b00 off, 2'b01 full, 2'b10 regulated and 2'b11 treated as off. In off mode the gate is low in the same cycle, and the counter is held at 0.
- R4: A high `abort_i` forces the gate low in the same cycle in every mode, including full, and holds the counter at 0.
- R5: In full mode without abort the gate is high on every tick of the period, starting in the cycle the mode is applied.
- R6: In regulated mode the on-time is GAIN × (setpoint − temperature) ticks, with GAIN = 10 by default. The gate is high while the counter is below the latched on-time. For example, 200 − 150 gives 500 high ticks out of 1500.
- R7: When the setpoint is at or below the temperature, the regulated on-time is 0 and the gate stays low for the whole period.
- R8: The on-time is clamped to 1500. An error of exactly 150 gives 1500, an error of 149 gives 1490, and any larger error gives 1500.
- R9: A changed setpoint or temperature during a regulated period does not alter that period. The new on-time is latched when the counter wraps to 0.
- R10: While off or aborted, the on-time latch follows the current request every cycle. When regulated mode resumes, a fresh period starts at count 0 with that on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 1 ms time strobe |
| mode_i | input | 2 | Heater mode: 00 off, 01 full, 10 regulated, 11 off |
| abort_i | input | 1 | Fault abort; forces the gate low |
| setpoint_i | input | TEMP_W (10) | Target temperature, whole degrees |
| temp_i | input | TEMP_W (10) | Measured temperature, whole degrees |
| ssr_gate_o | output | 1 | Active-high drive to the relay's low-side switch |

## Verification
Several properties are checked on every cycle:
- the counter stays in range and freezes without ticks;
- the counter returns to zero whenever the gate is forced off, and after a forced-off interval ends;
- the gate is low under off or abort, and high under full;
- the latched on-time never exceeds 1500 and changes only at count zero.

The arithmetic needs the bench's directed scenarios, which count high ticks over whole periods. These cover the proportional on-time, zero on negative error, the exact clamp threshold, and the deferred take-up of a new on-time.

// File: rtl/ssr_pwm_pkg.sv
package ssr_pwm_pkg;

    typedef enum logic [1:0] {
        HEAT_OFF  = 2'b00,
        HEAT_FULL = 2'b01,
        HEAT_REG  = 2'b10,
        HEAT_RSVD = 2'b11
    } heat_mode_e;

    typedef struct packed {
        logic force_low;   // gate held low, counter parked
        logic full_on;     // gate held high
        logic regulate;    // gate follows counter vs latched on-time
    } drive_ctl_t;

    function automatic drive_ctl_t decode_mode(input heat_mode_e mode, input logic abort);
        drive_ctl_t c;
        c = '{force_low: 1'b1, full_on: 1'b0, regulate: 1'b0};
        if (!abort) begin
            case (mode)
                HEAT_FULL: c = '{force_low: 1'b0, full_on: 1'b1, regulate: 1'b0};
                HEAT_REG:  c = '{force_low: 1'b0, full_on: 1'b0, regulate: 1'b1};
                default:   c = '{force_low: 1'b1, full_on: 1'b0, regulate: 1'b0};
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/ssr_pwm_duty_calc.sv
module ssr_pwm_duty_calc #(
    parameter int TEMP_W = 10,
    parameter int GAIN   = 10,
    parameter int PERIOD = 1500,
    parameter int DUTY_W = $clog2(PERIOD + 1)
) (
    input  logic [TEMP_W-1:0] setpoint_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic [DUTY_W-1:0] duty_o
);
    localparam int GAIN_W = $clog2(GAIN + 1);
    localparam int PROD_W = TEMP_W + GAIN_W + 1;

    logic [TEMP_W-1:0] err;
    logic [PROD_W-1:0] prod;

    always_comb begin
        err  = setpoint_i - temp_i;
        prod = PROD_W'(err) * PROD_W'(GAIN);
        if (setpoint_i <= temp_i) begin
            duty_o = '0;                       // R7: no heat above target
        end else if (prod > PROD_W'(PERIOD)) begin
            duty_o = DUTY_W'(PERIOD);          // R8: clamp to full period
        end else begin
            duty_o = prod[DUTY_W-1:0];         // R6
        end
    end

endmodule

// File: rtl/ssr_pwm_period_ctr.sv
module ssr_pwm_period_ctr #(
    parameter int PERIOD = 1500,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && !hold_i && (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);                                              // R2
    AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !hold_i) |=> $stable(cnt_q));                    // R2
    AST_HOLD_PARK: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_q == '0));                                   // R3

endmodule

// File: rtl/ssr_pwm_drv.sv
module ssr_pwm_drv
    import ssr_pwm_pkg::*;
#(
    parameter int TEMP_W = 10,
    parameter int GAIN   = 10,
    parameter int PERIOD = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [1:0]        mode_i,
    input  logic              abort_i,
    input  logic [TEMP_W-1:0] setpoint_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              ssr_gate_o
);
    localparam int CNT_W  = $clog2(PERIOD);
    localparam int DUTY_W = $clog2(PERIOD + 1);

    drive_ctl_t        ctl;
    logic [DUTY_W-1:0] duty_next;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;

    assign ctl = decode_mode(heat_mode_e'(mode_i), abort_i);

    ssr_pwm_duty_calc #(
        .TEMP_W (TEMP_W),
        .GAIN   (GAIN),
        .PERIOD (PERIOD),
        .DUTY_W (DUTY_W)
    ) u_duty (
        .setpoint_i (setpoint_i),
        .temp_i     (temp_i),
        .duty_o     (duty_next)
    );

    ssr_pwm_period_ctr #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .hold_i (ctl.force_low),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    // On-time latch: loads only at a period boundary or while parked (R9, R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (ctl.force_low || wrap) begin
            duty_q <= duty_next;
        end
    end

    always_comb begin
        if (ctl.force_low) begin
            ssr_gate_o = 1'b0;
        end else if (ctl.full_on) begin
            ssr_gate_o = 1'b1;
        end else begin
            ssr_gate_o = ctl.regulate && (DUTY_W'(cnt) < duty_q);
        end
    end

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (abort_i || mode_i == 2'b00 || mode_i == 2'b11) |-> !ssr_gate_o);   // R4
    AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
        (!abort_i && mode_i == 2'b01) |-> ssr_gate_o);                       // R5
    AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (rst)
        duty_q <= DUTY_W'(PERIOD));                                          // R8
    AST_DUTY_AT_START: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_q) |-> (cnt == '0));                                   // R9
    AST_FRESH_PERIOD: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.force_low) |-> (cnt == '0));                               // R10

endmodule

// File: tb/ssr_pwm_drv_tb.sv
module ssr_pwm_drv_tb;
    localparam int TEMP_W = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic [1:0]        mode;
    logic              abort;
    logic [TEMP_W-1:0] sp;
    logic [TEMP_W-1:0] pv;
    logic              gate;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ssr_pwm_drv #(.TEMP_W(TEMP_W), .GAIN(10), .PERIOD(1500)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .mode_i     (mode),
        .abort_i    (abort),
        .setpoint_i (sp),
        .temp_i     (pv),
        .ssr_gate_o (gate)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples the gate at n successive negedges, starting at the current one
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (gate) hi++;
            @(negedge clk);
        end
    endtask

    task automatic enter_reg(input int s, input int t);
        mode = 2'b00; abort = 1'b0;
        sp = TEMP_W'(s); pv = TEMP_W'(t);
        @(negedge clk);
        mode = 2'b10;
    endtask

    task automatic t_reset();
        int hi;
        @(negedge clk);
        rst = 1'b1; tick = 1'b1; mode = 2'b10; abort = 1'b0;
        sp = 10'd200; pv = 10'd150;
        repeat (3) @(negedge clk);
        #1 check("R1 gate in reset", gate, 0);
        @(negedge clk);
        rst = 1'b0;
        count_high(200, hi);
        check("R1 gate after reset with zero latch", hi, 0);
    endtask

    task automatic t_off();
        int hi;
        mode = 2'b00; sp = 10'd400; pv = 10'd20;
        @(negedge clk);
        count_high(300, hi);
        check("R3 off mode gate", hi, 0);
        mode = 2'b11;
        count_high(300, hi);
        check("R3 code 11 acts as off", hi, 0);
    endtask

    task automatic t_full();
        int hi;
        mode = 2'b00; @(negedge clk);
        mode = 2'b01;
        #1 check("R5 full immediate", gate, 1);
        count_high(1500, hi);
        check("R5 full period high ticks", hi, 1500);
    endtask

    task automatic t_reg_basic();
        int hi;
        enter_reg(200, 150);
        count_high(1500, hi);
        check("R6 500 of 1500", hi, 500);
        enter_reg(60, 37);
        count_high(1500, hi);
        check("R6 230 of 1500", hi, 230);
    endtask

    task automatic t_neg();
        int hi;
        enter_reg(150, 200);
        count_high(1500, hi);
        check("R7 negative error", hi, 0);
        enter_reg(180, 180);
        count_high(1500, hi);
        check("R7 zero error", hi, 0);
    endtask

    task automatic t_clamp();
        int hi;
        enter_reg(300, 150);
        count_high(1500, hi);
        check("R8 error 150 exact", hi, 1500);
        enter_reg(300, 151);
        count_high(1500, hi);
        check("R8 error 149", hi, 1490);
        enter_reg(900, 100);
        count_high(1500, hi);
        check("R8 large error clamp", hi, 1500);
    endtask

    task automatic t_deferred();
        int hi;
        enter_reg(200, 150);
        count_high(100, hi);
        check("R9 early part", hi, 100);
        pv = 10'd100;   // request becomes 1000
        count_high(1400, hi);
        check("R9 rest of old period", hi, 400);
        count_high(1500, hi);
        check("R9 next period new duty", hi, 1000);
    endtask

    task automatic t_abort();
        int hi;
        enter_reg(200, 150);
        count_high(10, hi);
        abort = 1'b1;
        #1 check("R4 abort same cycle", gate, 0);
        @(negedge clk);
        count_high(20, hi);
        check("R4 abort held", hi, 0);
        mode = 2'b01;
        #1 check("R4 abort overrides full", gate, 0);
        @(negedge clk);
        mode = 2'b10; sp = 10'd200; pv = 10'd170;  // latch follows: 300
        @(negedge clk);
        abort = 1'b0;
        #1 check("R10 restart high at count 0", gate, 1);
        count_high(1500, hi);
        check("R10 fresh period uses current request", hi, 300);
    endtask

    task automatic t_tick_freeze();
        int hi;
        enter_reg(200, 150);
        count_high(499, hi);
        check("R2 ticks up to 499", hi, 499);
        tick = 1'b0;
        count_high(50, hi);
        check("R2 frozen without tick", hi, 50);
        tick = 1'b1;
        count_high(1, hi);
        #1 check("R2 next tick crosses duty", gate, 0);
        tick = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; mode = 2'b00; abort = 1'b0;
        sp = '0; pv = '0;
        t_reset();
        t_off();
        t_full();
        t_reg_basic();
        t_neg();
        t_clamp();
        t_deferred();
        t_abort();
        t_tick_freeze();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule